// File: doc/BRIEF.md
# Legacy I/O Controller Configuration Port

This block is the configuration front end of a legacy multi-function I/O controller. The host sees two byte-wide locations. Writes to the index location (select 0) pick a register. Accesses to the data location (select 1) read or write that register. Configuration space stays closed until the host writes a key sequence to the index location.

The key sequence and the way to close the space again depend on a parameter. The four-byte style expects 0x87, 0x01, 0x55 and then a last byte that follows the port base: 0x55 for base 0x2E, 0xAA otherwise. It closes when 0x02 is written to register 0x02. The double-key style opens after 0x87 is written twice in a row, and it closes when 0xAA is written to the index location.

Registers below 0x30 are global and include the device-number selector at 0x07 and the identification bytes. Registers from 0x30 upward belong to whichever logical-device bank the selector names. Each bank's enable bit and two I/O base words are driven out to the peripherals downstream.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset, configuration space is closed, every enable output is 0, and the device-number selector reads back 0xFF once the space is opened.
- R2: In the four-byte style, the space opens only after consecutive index writes of 0x87, 0x01, 0x55 and a last byte chosen by the port base (0x55 for base 0x2E, 0xAA otherwise). A wrong last byte leaves the space closed.
- R3: An index write that does not match the next expected key byte restarts the sequence. If that byte is 0x87, it counts as the first key byte.
- R4: While the space is closed, data-location writes change nothing and data-location reads return 0xFF.
- R5: In the four-byte style, writing 0x02 through the data location while register 0x02 is selected closes the space.
- R6: In the double-key style, two consecutive index writes of 0x87 open the space, and an index write of 0xAA closes it without changing the selected register.
- R7: Register 0x20 returns the high byte of the chip identifier and register 0x21 its low byte. Register 0x22 returns the revision byte in the four-byte style and 0x00 in the double-key style.
- R8: Writes to the identification registers 0x20 to 0x22 are discarded.
- R9: Register 0x07 holds the device number. Registers from 0x30 upward are kept separately for each bank, so a write in one bank is not seen in another.
- R10: Each bank holds an enable register at 0x30 (bit 0 drives dev_active), base words at 0x60/0x61 and 0x62/0x63 (high byte at the lower index, driven on dev_iobase and dev_iobase2 in 16-bit slices by bank), an interrupt select at 0x70 and a DMA select at 0x74. Any other banked index reads 0x00.
- R11: When the device number is NUM_DEV or above (including 0xFF), banked reads return 0xFF and banked writes are dropped.
- R12: While the space is open, reading the index location returns the selected register number. While it is closed, the read returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Write strobe, one cycle per byte |
| host_re | input | 1 | Read strobe; read data is valid in the same cycle |
| host_sel | input | 1 | 0 selects the index location, 1 selects the data location |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte (0xFF when no read is in progress) |
| cfg_open | output | 1 | Configuration space is open |
| dev_active | output | NUM_DEV | Bit 0 of each bank's enable register |
| dev_iobase | output | 16*NUM_DEV | Primary base word of each bank |
| dev_iobase2 | output | 16*NUM_DEV | Secondary base word of each bank |

## Verification
One index write can both abort a partial key sequence and start a new one. This happens when the byte is 0x87 arriving at a step that expects something else. The bench provokes it with 0x87, 0x01, 0x87, 0x01, 0x55, 0x55. The block must treat the second 0x87 as step one, so the space has to be open after the final byte and the index read must return the register number rather than 0xFF. The second overlap is the closing write in the four-byte style: a data write that is also the exit command. The bench confirms that this write closes the space and touches no bank.

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter bit          USE_DOUBLE_KEY = 1'b0,
  parameter logic [15:0] PORT_BASE      = 16'h002E,
  parameter int          NUM_DEV        = 16,
  parameter logic [15:0] CHIP_ID        = 16'h8712,
  parameter logic [7:0]  REV_ID         = 8'h05
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_we,
  input  logic                  host_re,
  input  logic                  host_sel,
  input  logic [7:0]            host_wdata,
  output logic [7:0]            host_rdata,
  output logic                  cfg_open,
  output logic [NUM_DEV-1:0]    dev_active,
  output logic [16*NUM_DEV-1:0] dev_iobase,
  output logic [16*NUM_DEV-1:0] dev_iobase2
);
  localparam int          DW        = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;
  localparam int          KEY_LEN   = USE_DOUBLE_KEY ? 2 : 4;
  localparam logic [8:0]  DEV_LIMIT = 9'(NUM_DEV);
  localparam logic [7:0]  LAST_KEY  = (PORT_BASE == 16'h002E) ? 8'h55 : 8'hAA;

  logic        open_q;
  logic [1:0]  step_q;
  logic [7:0]  idx_q;
  logic [7:0]  ldn_q;
  logic [7:0]  act_q   [NUM_DEV];
  logic [15:0] base0_q [NUM_DEV];
  logic [15:0] base1_q [NUM_DEV];
  logic [7:0]  irq_q   [NUM_DEV];
  logic [7:0]  dma_q   [NUM_DEV];
  logic [7:0]  rd;

  function automatic logic [7:0] key_byte(input logic [1:0] s);
    if (USE_DOUBLE_KEY) return 8'h87;
    case (s)
      2'd0:    return 8'h87;
      2'd1:    return 8'h01;
      2'd2:    return 8'h55;
      default: return LAST_KEY;
    endcase
  endfunction

  wire          idx_wr   = host_we & ~host_sel;
  wire          dat_wr   = host_we & host_sel;
  wire          bank_ok  = {1'b0, ldn_q} < DEV_LIMIT;
  wire [DW-1:0] sel_dev  = ldn_q[DW-1:0];
  wire          banked   = idx_q >= 8'h30;
  wire          key_hit  = host_wdata == key_byte(step_q);
  wire          key_last = step_q == 2'(KEY_LEN - 1);
  wire          exit_req = USE_DOUBLE_KEY ? (idx_wr && host_wdata == 8'hAA)
                                          : (dat_wr && idx_q == 8'h02 && host_wdata == 8'h02);
  wire          bank_wr  = open_q & dat_wr & banked & bank_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      step_q <= 2'd0;
      idx_q  <= 8'h00;
      ldn_q  <= 8'hFF;
    end else if (!open_q) begin
      if (idx_wr) begin
        if (key_hit) begin
          if (key_last) begin
            open_q <= 1'b1;
            step_q <= 2'd0;
          end else begin
            step_q <= step_q + 2'd1;
          end
        end else begin
          step_q <= (host_wdata == 8'h87) ? 2'd1 : 2'd0;
        end
      end
    end else begin
      if (exit_req)                      open_q <= 1'b0;
      else if (idx_wr)                   idx_q  <= host_wdata;
      else if (dat_wr && idx_q == 8'h07) ldn_q  <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DEV; i++) begin
        act_q[i]   <= 8'h00;
        base0_q[i] <= 16'h0000;
        base1_q[i] <= 16'h0000;
        irq_q[i]   <= 8'h00;
        dma_q[i]   <= 8'h00;
      end
    end else if (bank_wr) begin
      case (idx_q)
        8'h30: act_q[sel_dev]         <= host_wdata;
        8'h60: base0_q[sel_dev][15:8] <= host_wdata;
        8'h61: base0_q[sel_dev][7:0]  <= host_wdata;
        8'h62: base1_q[sel_dev][15:8] <= host_wdata;
        8'h63: base1_q[sel_dev][7:0]  <= host_wdata;
        8'h70: irq_q[sel_dev]         <= host_wdata;
        8'h74: dma_q[sel_dev]         <= host_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd = 8'hFF;
    if (host_re && open_q) begin
      if (!host_sel) begin
        rd = idx_q;
      end else if (banked) begin
        if (bank_ok) begin
          case (idx_q)
            8'h30:   rd = act_q[sel_dev];
            8'h60:   rd = base0_q[sel_dev][15:8];
            8'h61:   rd = base0_q[sel_dev][7:0];
            8'h62:   rd = base1_q[sel_dev][15:8];
            8'h63:   rd = base1_q[sel_dev][7:0];
            8'h70:   rd = irq_q[sel_dev];
            8'h74:   rd = dma_q[sel_dev];
            default: rd = 8'h00;
          endcase
        end
      end else begin
        case (idx_q)
          8'h07:   rd = ldn_q;
          8'h20:   rd = CHIP_ID[15:8];
          8'h21:   rd = CHIP_ID[7:0];
          8'h22:   rd = USE_DOUBLE_KEY ? 8'h00 : REV_ID;
          default: rd = 8'h00;
        endcase
      end
    end
  end

  assign host_rdata = rd;
  assign cfg_open   = open_q;

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank_out
    assign dev_active[g]            = act_q[g][0];
    assign dev_iobase[g*16 +: 16]   = base0_q[g];
    assign dev_iobase2[g*16 +: 16]  = base1_q[g];
  end
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter bit          USE_DOUBLE_KEY = 1'b0,
  parameter int          NUM_DEV        = 16,
  parameter logic [15:0] CHIP_ID        = 16'h8712
) (
  input logic               clk,
  input logic               rst_n,
  input logic               we,
  input logic               re,
  input logic               sel,
  input logic [7:0]         wdata,
  input logic [7:0]         rdata,
  input logic               open,
  input logic [7:0]         idx,
  input logic [NUM_DEV-1:0] active
);
  p_closed_read_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!open && re && sel) |-> rdata == 8'hFF);

  p_closed_banks_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !open |=> $stable(active));

  p_opens_on_index_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(we && !sel));

  p_id_high_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (open && re && sel && idx == 8'h20) |-> rdata == CHIP_ID[15:8]);

  if (USE_DOUBLE_KEY) begin : g_exit_dbl
    p_index_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (open && we && !sel && wdata == 8'hAA) |=> !open);
  end else begin : g_exit_four
    p_data_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (open && we && sel && idx == 8'h02 && wdata == 8'h02) |=> !open);
  end
endmodule

bind sio_cfg_port sio_cfg_port_chk #(
  .USE_DOUBLE_KEY(USE_DOUBLE_KEY),
  .NUM_DEV(NUM_DEV),
  .CHIP_ID(CHIP_ID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .we(host_we), .re(host_re), .sel(host_sel),
  .wdata(host_wdata), .rdata(host_rdata), .open(open_q), .idx(idx_q),
  .active(dev_active)
);

// File: tb/sio_cfg_port_tb.sv
`timescale 1ns/1ps
module sio_cfg_port_tb;
  localparam int NA = 16;
  localparam int NB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we_a = 1'b0, we_b = 1'b0, re_a = 1'b0, re_b = 1'b0;
  logic sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rd_a, rd_b;
  logic open_a, open_b;
  logic [NA-1:0] act_a;
  logic [NB-1:0] act_b;
  logic [16*NA-1:0] base_a, base2_a;
  logic [16*NB-1:0] base_b, base2_b;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sio_cfg_port #(.USE_DOUBLE_KEY(1'b0), .PORT_BASE(16'h002E), .NUM_DEV(NA),
                 .CHIP_ID(16'h8712), .REV_ID(8'h05)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_we(we_a), .host_re(re_a), .host_sel(sel),
    .host_wdata(wdata), .host_rdata(rd_a), .cfg_open(open_a), .dev_active(act_a),
    .dev_iobase(base_a), .dev_iobase2(base2_a));

  sio_cfg_port #(.USE_DOUBLE_KEY(1'b1), .PORT_BASE(16'h004E), .NUM_DEV(NB),
                 .CHIP_ID(16'hB47A), .REV_ID(8'h33)) u_dut_b (
    .clk(clk), .rst_n(rst_n), .host_we(we_b), .host_re(re_b), .host_sel(sel),
    .host_wdata(wdata), .host_rdata(rd_b), .cfg_open(open_b), .dev_active(act_b),
    .dev_iobase(base_b), .dev_iobase2(base2_b));

  function automatic logic [14:0] vw(input int rq, input bit tgt, input bit s, input logic [7:0] d);
    return {4'(rq), tgt, 1'b0, s, d};
  endfunction
  function automatic logic [14:0] vr(input int rq, input bit tgt, input bit s, input logic [7:0] e);
    return {4'(rq), tgt, 1'b1, s, e};
  endfunction

  localparam int NV = 61;
  localparam logic [14:0] VEC [NV] = '{
    vr(4,0,1,8'hFF), vw(4,0,1,8'h5A),                                      // R4 closed
    vw(2,0,0,8'h87), vw(2,0,0,8'h01), vw(2,0,0,8'h55), vw(2,0,0,8'hAA),    // R2 wrong last byte
    vr(2,0,0,8'hFF),
    vw(3,0,0,8'h87), vw(3,0,0,8'h01), vw(3,0,0,8'h87), vw(3,0,0,8'h01),    // R3 restart on 0x87
    vw(3,0,0,8'h55), vw(3,0,0,8'h55),
    vr(12,0,0,8'h00),                                                      // R12
    vw(7,0,0,8'h20), vr(7,0,1,8'h87), vw(7,0,0,8'h21), vr(7,0,1,8'h12),    // R7
    vw(7,0,0,8'h22), vr(7,0,1,8'h05),
    vw(8,0,0,8'h20), vw(8,0,1,8'h00), vr(8,0,1,8'h87),                     // R8
    vw(11,0,0,8'h30), vr(11,0,1,8'hFF), vw(11,0,1,8'h01),                  // R11 none selected
    vw(9,0,0,8'h07), vw(9,0,1,8'h03), vr(9,0,1,8'h03),                     // R9
    vw(10,0,0,8'h30), vw(10,0,1,8'h01), vr(10,0,1,8'h01),                  // R10
    vw(10,0,0,8'h60), vw(10,0,1,8'h12), vw(10,0,0,8'h61), vw(10,0,1,8'h34),
    vw(10,0,0,8'h70), vw(10,0,1,8'h05), vr(10,0,1,8'h05),
    vw(10,0,0,8'h62), vw(10,0,1,8'h0A), vw(10,0,0,8'h63), vw(10,0,1,8'h0B),
    vw(9,0,0,8'h07), vw(9,0,1,8'h04), vw(9,0,0,8'h30), vr(9,0,1,8'h00),    // R9 other bank
    vw(9,0,0,8'h07), vw(9,0,1,8'h03), vw(10,0,0,8'h60), vr(10,0,1,8'h12),
    vw(11,0,0,8'h07), vw(11,0,1,8'h10), vw(11,0,0,8'h61), vr(11,0,1,8'hFF),// R11 above range
    vw(9,0,0,8'h07), vw(9,0,1,8'h03),
    vw(5,0,0,8'h02), vw(5,0,1,8'h02), vr(5,0,1,8'hFF),                     // R5 exit
    vr(12,0,0,8'hFF)
  };

  task automatic apply(input logic [14:0] v);
    logic [7:0] got;
    @(negedge clk);
    sel   = v[8];
    wdata = v[7:0];
    we_a  = !v[9] && !v[10];
    we_b  = !v[9] &&  v[10];
    re_a  =  v[9] && !v[10];
    re_b  =  v[9] &&  v[10];
    if (v[9]) begin
      #5;
      got = v[10] ? rd_b : rd_a;
      checks++;
      if (got !== v[7:0]) begin
        fails++;
        $display("FAIL R%0d dut%s sel=%0d actual=%02h expected=%02h",
                 v[14:11], v[10] ? "_b" : "", v[8], got, v[7:0]);
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    we_a = 0; we_b = 0; re_a = 0; re_b = 0;
  endtask

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, got, exp);
    end
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #5;
    chk("R1 open_a", 32'(open_a), 0);
    chk("R1 act_a", 32'(act_a), 0);
    chk("R1 open_b", 32'(open_b), 0);

    for (int i = 0; i < NV; i++) apply(VEC[i]);
    idle();
    #5;
    chk("R10 act_a", 32'(act_a), 32'h0008);
    chk("R10 base_a", 32'(base_a[3*16 +: 16]), 32'h1234);
    chk("R10 base2_a", 32'(base2_a[3*16 +: 16]), 32'h0A0B);
    chk("R5 open_a", 32'(open_a), 0);

    // R6 double-key style, R4 closed write on second instance
    apply(vr(6,1,1,8'hFF));
    apply(vw(6,1,0,8'h87)); apply(vw(6,1,0,8'h87));
    apply(vw(7,1,0,8'h20)); apply(vr(7,1,1,8'hB4));
    apply(vw(7,1,0,8'h22)); apply(vr(7,1,1,8'h00));
    apply(vw(10,1,0,8'h07)); apply(vw(10,1,1,8'h01));
    apply(vw(10,1,0,8'h74)); apply(vw(10,1,1,8'h03)); apply(vr(10,1,1,8'h03));
    apply(vw(6,1,0,8'hAA)); apply(vr(6,1,1,8'hFF)); apply(vr(6,1,0,8'hFF));
    apply(vw(4,1,1,8'h09));
    apply(vw(4,1,0,8'h87)); apply(vw(4,1,0,8'h87));
    apply(vr(4,1,1,8'h03)); apply(vr(12,1,0,8'h74));
    idle();
    #5;
    chk("R6 act_b", 32'(act_b), 0);

    // R1 reset mid-run clears banks and selector
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    #5;
    chk("R1 act_a after reset", 32'(act_a), 0);
    chk("R1 open_a after reset", 32'(open_a), 0);
    apply(vw(1,0,0,8'h87)); apply(vw(1,0,0,8'h01));
    apply(vw(1,0,0,8'h55)); apply(vw(1,0,0,8'h55));
    apply(vw(1,0,0,8'h07)); apply(vr(1,0,1,8'hFF));
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule